// File: doc/BRIEF.md
# Serial Audio Transmitter with I2S and TDM Framing

This block turns a stream of parallel audio samples into a serial audio link. It divides its master clock into a bit clock, derives a frame clock from it, and shifts every sample out most significant bit first. The link runs either as a plain two-channel I2S port or as a multi-slot TDM port with a one-bit-wide frame sync pulse (DSP-A style).

Three write-only registers set the port up. The control word enables the port, picks the framing and sets the sample resolution. The TDM format word sets the slot count and the slot width. The divider word sets the number of master clock cycles in one bit clock period.

Samples arrive on a valid/ready input, and the block takes one sample at the start of every slot. If no sample is waiting at a slot start, the slot is sent as zeros and a sticky underrun flag is raised.

Top module: `ser_audio_tx`

## Requirements
- R1: After reset, `bclk_o`, `fsync_o`, `sdata_o`, `smp_ready` and `underrun_o` are all low, the port is disabled, and the divider holds `DEF_RATIO` (4).
- R2: Register address 2 sets the divider ratio R in bits [15:0]. The bit clock period is R master cycles: low for the first floor(R/2) cycles of the period and high for the rest. A write with R below 2 is ignored.
- R3: Control (address 0) bit 0 enables the port and bit 1 = 0 selects I2S. In I2S mode a frame is a left channel (`fsync_o` low) followed by a right channel (`fsync_o` high). Each channel is 16 bit periods long for 8- and 16-bit samples and 32 long for 24- and 32-bit samples. Data is sent MSB first, starting one bit period after the frame clock edge.
- R4: Control bits [5:3] hold the resolution code: 0 = 8, 2 = 16, 4 = 24, 5 = 32 bits. The sample is taken from the low bits of `smp_data` at that width, and the bits of a slot after the sample's LSB are sent as zeros.
- R5: A control write whose resolution code is not 0, 2, 4 or 5 is rejected as a whole, so a rejected write that sets the enable bit leaves the port idle.
- R6: With control bit 1 = 1 (TDM), `fsync_o` is high for exactly the first bit period of each frame, and the MSB of slot 0 follows in the next period. N slots of W bits each then follow back to back, where N is set by format (address 1) bits [17:15] (1..7, with 0 meaning 8) and W by bits [22:18] (8, 16, 24, with 0 meaning 32).
- R7: A format write whose width code is not 0, 8, 16 or 24 is rejected and the previous slot geometry stays in force.
- R8: When `smp_valid` is low at a slot start, that slot carries zeros and `underrun_o` rises and stays high until reset.
- R9: `smp_ready` is high for exactly one master cycle at each slot start and only while the port is enabled, so exactly one sample is consumed per slot.
- R10: After the enable bit is cleared, `bclk_o`, `fsync_o` and `sdata_o` go low within one master cycle and no further bit clock edges or sample requests occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 control, 1 TDM format, 2 divider |
| cfg_wdata | input | 32 | Register write data |
| smp_valid | input | 1 | A sample is offered |
| smp_data | input | 32 | Sample, right-justified at the configured resolution |
| smp_ready | output | 1 | Sample taken this cycle |
| bclk_o | output | 1 | Serial bit clock |
| fsync_o | output | 1 | Frame clock (I2S) or frame sync pulse (TDM) |
| sdata_o | output | 1 | Serial data, changes while the bit clock is low |
| underrun_o | output | 1 | Sticky flag: a slot went out without a sample |

## Verification
A slot or bit counter that slips shows up at the serial pins within one frame: the frame clock edge lands on the wrong bit period, and every following bit of the captured stream stops matching the sample model. A shift register that loads at the wrong moment corrupts the very next slot, and a missed load is seen as an extra or a missing `smp_ready` pulse, so the consumed-sample count after a known number of bit periods differs from one per slot. Divider faults change the spacing between bit clock rising edges on the first period after enable.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;

    localparam int SMP_W = 32;

    // register select values
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_FMT  = 2'd1;
    localparam logic [1:0] ADDR_DIV  = 2'd2;

    // field positions
    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_TDM_BIT  = 1;
    localparam int CTL_RES_LSB  = 3;
    localparam int FMT_SLOT_LSB = 15;
    localparam int FMT_WID_LSB  = 18;

    // decoded configuration seen by the datapath
    typedef struct packed {
        logic       en;
        logic       tdm;
        logic [5:0] res_bits;
        logic [3:0] slots;
        logic [5:0] width;
    } tx_cfg_t;

    function automatic logic res_code_ok(input logic [2:0] code);
        return (code == 3'd0) || (code == 3'd2) || (code == 3'd4) || (code == 3'd5);
    endfunction

    function automatic logic [5:0] res_code_bits(input logic [2:0] code);
        case (code)
            3'd0:    return 6'd8;
            3'd4:    return 6'd24;
            3'd5:    return 6'd32;
            default: return 6'd16;
        endcase
    endfunction

    function automatic logic wid_code_ok(input logic [4:0] code);
        return (code == 5'd0) || (code == 5'd8) || (code == 5'd16) || (code == 5'd24);
    endfunction

endpackage

// File: rtl/atx_regs.sv
module atx_regs
    import audio_tx_pkg::*;
#(
    parameter int DIV_W     = 16,
    parameter int DEF_RATIO = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [31:0]      wr_data,
    output tx_cfg_t          cfg_o,
    output logic [DIV_W-1:0] ratio_o
);

    typedef struct packed {
        logic             en;
        logic             tdm;
        logic [2:0]       res_code;
        logic [2:0]       slot_code;
        logic [4:0]       wid_code;
        logic [DIV_W-1:0] ratio;
    } reg_st_t;

    reg_st_t st_d, st_q;

    logic [2:0]       new_res;
    logic [2:0]       new_slot;
    logic [4:0]       new_wid;
    logic [DIV_W-1:0] new_ratio;

    always_comb begin
        new_res   = wr_data[CTL_RES_LSB +: 3];
        new_slot  = wr_data[FMT_SLOT_LSB +: 3];
        new_wid   = wr_data[FMT_WID_LSB +: 5];
        new_ratio = wr_data[DIV_W-1:0];
        st_d      = st_q;
        if (wr_en) begin
            case (wr_addr)
                ADDR_CTRL: if (res_code_ok(new_res)) begin
                    st_d.en       = wr_data[CTL_EN_BIT];
                    st_d.tdm      = wr_data[CTL_TDM_BIT];
                    st_d.res_code = new_res;
                end
                ADDR_FMT: if (wid_code_ok(new_wid)) begin
                    st_d.slot_code = new_slot;
                    st_d.wid_code  = new_wid;
                end
                ADDR_DIV: if (new_ratio >= DIV_W'(2)) begin
                    st_d.ratio = new_ratio;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.ratio <= DIV_W'(DEF_RATIO);
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cfg_o.en       = st_q.en;
        cfg_o.tdm      = st_q.tdm;
        cfg_o.res_bits = res_code_bits(st_q.res_code);
        cfg_o.slots    = (st_q.slot_code == 3'd0) ? 4'd8 : {1'b0, st_q.slot_code};
        cfg_o.width    = (st_q.wid_code == 5'd0) ? 6'd32 : {1'b0, st_q.wid_code};
        ratio_o        = st_q.ratio;
    end

endmodule

// File: rtl/atx_clkgen.sv
module atx_clkgen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] ratio,
    output logic             bclk_o,
    output logic             tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             bclk;
    } clk_st_t;

    clk_st_t st_d, st_q;

    logic [DIV_W-1:0] half;
    logic [DIV_W-1:0] last;

    always_comb begin
        half   = ratio >> 1;
        last   = ratio - DIV_W'(1);
        tick_o = en && (st_q.cnt >= last);
        st_d   = st_q;
        if (!en) begin
            // parked at the top so the first enabled cycle starts a period
            st_d.cnt  = '1;
            st_d.bclk = 1'b0;
        end else if (tick_o) begin
            st_d.cnt  = '0;
            st_d.bclk = 1'b0;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
            if (st_q.cnt == half - DIV_W'(1)) begin
                st_d.bclk = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt  <= '1;
            st_q.bclk <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bclk_o = st_q.bclk;

endmodule

// File: rtl/atx_framer.sv
module atx_framer
    import audio_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  tx_cfg_t          cfg,
    input  logic             tick,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    output logic             smp_ready,
    output logic             fsync_o,
    output logic             sdata_o,
    output logic             underrun_o
);

    localparam int CNT_W = $clog2(SMP_W) + 1;

    typedef struct packed {
        logic             idle;
        logic [CNT_W-1:0] bitc;
        logic [2:0]       slot;
        logic [SMP_W-1:0] shreg;
        logic             fs;
        logic             sd;
        logic             urun;
    } fr_st_t;

    fr_st_t st_d, st_q;

    logic [CNT_W-1:0] slot_len;
    logic [3:0]       nslots;
    logic             last_bit;
    logic             last_slot;
    logic             load;
    logic [2:0]       nidx;
    logic [SMP_W-1:0] mask;
    logic [SMP_W-1:0] aligned;

    always_comb begin
        // slot geometry for the selected framing
        if (cfg.tdm) begin
            slot_len = CNT_W'(cfg.width);
            nslots   = cfg.slots;
        end else begin
            slot_len = (cfg.res_bits <= 6'd16) ? CNT_W'(16) : CNT_W'(32);
            nslots   = 4'd2;
        end
        last_bit  = st_q.bitc >= (slot_len - CNT_W'(1));
        last_slot = {1'b0, st_q.slot} >= (nslots - 4'd1);
        load      = tick && (st_q.idle || last_bit);
        nidx      = (st_q.idle || last_slot) ? 3'd0 : st_q.slot + 3'd1;

        // left-align the right-justified sample, zero below its LSB
        mask    = (cfg.res_bits >= 6'(SMP_W)) ? '1
                : ((SMP_W'(1) << cfg.res_bits) - SMP_W'(1));
        aligned = (smp_data & mask) << (6'(SMP_W) - cfg.res_bits);

        st_d = st_q;
        if (!cfg.en) begin
            st_d.idle  = 1'b1;
            st_d.bitc  = '0;
            st_d.slot  = '0;
            st_d.shreg = '0;
            st_d.fs    = 1'b0;
            st_d.sd    = 1'b0;
        end else if (tick) begin
            st_d.idle = 1'b0;
            st_d.sd   = st_q.shreg[SMP_W-1];
            if (load) begin
                st_d.bitc  = '0;
                st_d.slot  = nidx;
                st_d.shreg = smp_valid ? aligned : '0;
                st_d.urun  = st_q.urun | ~smp_valid;
                st_d.fs    = cfg.tdm ? (nidx == 3'd0) : (nidx == 3'd1);
            end else begin
                st_d.bitc  = st_q.bitc + CNT_W'(1);
                st_d.shreg = st_q.shreg << 1;
                st_d.fs    = cfg.tdm ? 1'b0 : st_q.fs;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.idle <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign smp_ready  = load;
    assign fsync_o    = st_q.fs;
    assign sdata_o    = st_q.sd;
    assign underrun_o = st_q.urun;

endmodule

// File: rtl/ser_audio_tx.sv
module ser_audio_tx
    import audio_tx_pkg::*;
#(
    parameter int DIV_W     = 16,
    parameter int DEF_RATIO = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    input  logic        smp_valid,
    input  logic [31:0] smp_data,
    output logic        smp_ready,
    output logic        bclk_o,
    output logic        fsync_o,
    output logic        sdata_o,
    output logic        underrun_o
);

    tx_cfg_t          cfg;
    logic [DIV_W-1:0] ratio;
    logic             tick;
    logic             port_en;

    assign port_en = cfg.en;

    atx_regs #(
        .DIV_W    (DIV_W),
        .DEF_RATIO(DEF_RATIO)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_addr(cfg_addr),
        .wr_data(cfg_wdata),
        .cfg_o  (cfg),
        .ratio_o(ratio)
    );

    atx_clkgen #(
        .DIV_W(DIV_W)
    ) u_clk (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cfg.en),
        .ratio (ratio),
        .bclk_o(bclk_o),
        .tick_o(tick)
    );

    atx_framer u_frm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .tick      (tick),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .smp_ready (smp_ready),
        .fsync_o   (fsync_o),
        .sdata_o   (sdata_o),
        .underrun_o(underrun_o)
    );

endmodule

// File: rtl/ser_audio_tx_chk.sv
module ser_audio_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic bclk,
    input logic fsync,
    input logic sdata,
    input logic ready,
    input logic valid,
    input logic urun
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!bclk && !fsync && !sdata)); // R10

    AST_READY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> en); // R9

    AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready); // R9

    AST_URUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        urun |=> urun); // R8

    AST_URUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(urun) |-> $past(ready && !valid)); // R8

    AST_SDATA_BCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata) |-> !bclk); // R3

    AST_FSYNC_BCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fsync) |-> !bclk); // R6

endmodule

bind ser_audio_tx ser_audio_tx_chk u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (port_en),
    .bclk (bclk_o),
    .fsync(fsync_o),
    .sdata(sdata_o),
    .ready(smp_ready),
    .valid(smp_valid),
    .urun (underrun_o)
);

// File: tb/tb_ser_audio_tx.sv
module tb_ser_audio_tx;

    localparam int CAP_MAX = 600;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic        smp_valid = 1'b0;
    logic [31:0] smp_data = 32'd0;
    logic        smp_ready, bclk_o, fsync_o, sdata_o, underrun_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ser_audio_tx dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .smp_valid(smp_valid), .smp_data(smp_data),
        .smp_ready(smp_ready), .bclk_o(bclk_o), .fsync_o(fsync_o),
        .sdata_o(sdata_o), .underrun_o(underrun_o)
    );

    function automatic logic [31:0] src_word(input int k);
        return (32'h9E3779B9 * (k + 1)) ^ 32'h5A5A0F0F;
    endfunction

    // sample source
    int ptr = 0;
    int src_cnt = 64;
    bit hs_pend = 0;
    bit src_clr = 0;
    always @(negedge clk) begin
        if (src_clr) begin
            ptr = 0;
            hs_pend = 0;
        end else if (hs_pend) begin
            ptr++;
        end
        smp_valid = (ptr < src_cnt);
        smp_data  = src_word(ptr);
        hs_pend   = smp_valid && smp_ready && !src_clr;
    end

    // receiver: sample on each bit clock rising edge
    bit fs_a [CAP_MAX];
    bit sd_a [CAP_MAX];
    int cyc_a [CAP_MAX];
    int cap_n = 0;
    int cyc = 0;
    bit prev_bclk = 0;
    bit cap_clr = 0;
    always @(negedge clk) begin
        if (cap_clr) begin
            cap_n = 0;
        end else if (bclk_o && !prev_bclk && cap_n < CAP_MAX) begin
            fs_a[cap_n]  = fsync_o;
            sd_a[cap_n]  = sdata_o;
            cyc_a[cap_n] = cyc;
            cap_n++;
        end
        prev_bclk = bclk_o;
        cyc++;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    int ptr_snap;

    // enable with ctrl, capture nb bit periods, disable and check quiet port
    task automatic run_scn(input logic [31:0] ctrl, input int nb);
        int g;
        int snap;
        src_clr = 1; cap_clr = 1;
        @(negedge clk); @(negedge clk);
        src_clr = 0; cap_clr = 0;
        cfg_write(2'd0, ctrl);
        g = 0;
        while (cap_n < nb && g < 50000) begin
            @(posedge clk);
            g++;
        end
        ptr_snap = ptr;
        check(g < 50000, "R3", "capture completed", cap_n, nb);
        cfg_write(2'd0, ctrl & ~32'd1);
        repeat (3) @(posedge clk);
        snap = cap_n;
        repeat (20) @(posedge clk);
        @(negedge clk);
        check(cap_n == snap && !bclk_o && !fsync_o && !sdata_o && !smp_ready,
              "R10", "port quiet after disable", cap_n - snap, 0);
    endtask

    // compare the captured stream against the framing model
    task automatic check_stream(input bit tdm, input int res, input int nsl,
                                input int sl, input int nb, input int srcn,
                                input string req);
        int fl;
        int bad_sd, bad_fs, first_sd, first_fs;
        fl = nsl * sl;
        bad_sd = 0; bad_fs = 0; first_sd = -1; first_fs = -1;
        for (int i = 0; i < nb; i++) begin
            int r, f, s, j, k, pos;
            bit esd, efs;
            logic [31:0] w;
            r = i - 1;
            esd = 1'b0;
            if (r >= 0) begin
                f = r / fl;
                s = (r % fl) / sl;
                j = r % sl;
                k = f * nsl + s;
                w = src_word(k);
                if (k < srcn && j < res && j < sl) esd = w[res - 1 - j];
            end
            pos = i % fl;
            efs = tdm ? (pos == 0) : (pos >= sl);
            if (sd_a[i] != esd) begin
                bad_sd++;
                if (first_sd < 0) first_sd = i;
            end
            if (fs_a[i] != efs) begin
                bad_fs++;
                if (first_fs < 0) first_fs = i;
            end
        end
        check(bad_sd == 0, req, $sformatf("data bits wrong (first at %0d)", first_sd), bad_sd, 0);
        check(bad_fs == 0, req, $sformatf("frame clock wrong (first at %0d)", first_fs), bad_fs, 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(!bclk_o && !fsync_o && !sdata_o && !smp_ready && !underrun_o,
              "R1", "outputs low after reset",
              {bclk_o, fsync_o, sdata_o, smp_ready, underrun_o}, 0);
        repeat (10) @(negedge clk);
        check(cap_n == 0, "R1", "port disabled after reset", cap_n, 0);
    endtask

    task automatic t_i2s16;
        run_scn(32'h11, 96);           // enable, I2S, code 2
        check_stream(1'b0, 16, 2, 16, 96, 64, "R3");
        check(ptr_snap == 6, "R9", "one sample per slot", ptr_snap, 6);
        check(cyc_a[1] - cyc_a[0] == 4, "R1", "default divider ratio", cyc_a[1] - cyc_a[0], 4);
    endtask

    task automatic t_i2s_res;
        run_scn(32'h29, 128);          // code 5: 32 bit
        check_stream(1'b0, 32, 2, 32, 128, 64, "R4");
        run_scn(32'h21, 128);          // code 4: 24 bit in 32-bit channels
        check_stream(1'b0, 24, 2, 32, 128, 64, "R4");
        run_scn(32'h01, 64);           // code 0: 8 bit in 16-bit channels
        check_stream(1'b0, 8, 2, 16, 64, 64, "R4");
    endtask

    task automatic t_bad_res;
        cap_clr = 1; @(negedge clk); cap_clr = 0;
        cfg_write(2'd0, 32'h19);       // enable with code 3
        repeat (40) @(negedge clk);
        check(cap_n == 0 && !smp_ready, "R5", "invalid resolution keeps port idle", cap_n, 0);
        cfg_write(2'd0, 32'h39);       // code 7
        repeat (40) @(negedge clk);
        check(cap_n == 0, "R5", "invalid resolution code 7 rejected", cap_n, 0);
    endtask

    task automatic t_tdm;
        cfg_write(2'd1, (32'd3 << 15) | (32'd16 << 18));
        run_scn(32'h13, 144);          // TDM, 16 bit, 3 slots x 16
        check_stream(1'b1, 16, 3, 16, 144, 64, "R6");
        check(ptr_snap == 9, "R9", "one sample per TDM slot", ptr_snap, 9);
        cfg_write(2'd1, 32'd0);        // 8 slots x 32
        run_scn(32'h23, 512);          // TDM, 24 bit
        check_stream(1'b1, 24, 8, 32, 512, 64, "R6");
    endtask

    task automatic t_bad_wid;
        cfg_write(2'd1, (32'd4 << 15) | (32'd8 << 18));
        cfg_write(2'd1, (32'd2 << 15) | (32'd12 << 18));   // rejected
        run_scn(32'h03, 96);           // TDM, 8 bit
        check_stream(1'b1, 8, 4, 8, 96, 64, "R7");
    endtask

    task automatic t_divider;
        cfg_write(2'd2, 32'd6);
        cfg_write(2'd2, 32'd1);        // rejected
        run_scn(32'h11, 4);
        check(cyc_a[1] - cyc_a[0] == 6, "R2", "bit clock period", cyc_a[1] - cyc_a[0], 6);
        check(cyc_a[3] - cyc_a[2] == 6, "R2", "bit clock period steady", cyc_a[3] - cyc_a[2], 6);
        cfg_write(2'd2, 32'd4);
    endtask

    task automatic t_underrun;
        @(negedge clk);
        check(!underrun_o, "R8", "no underrun with samples available", underrun_o, 0);
        src_cnt = 3;
        run_scn(32'h11, 64);
        check_stream(1'b0, 16, 2, 16, 64, 3, "R8");
        check(underrun_o == 1'b1, "R8", "underrun flag sticky", underrun_o, 1);
        src_cnt = 64;
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_i2s16();
        t_i2s_res();
        t_bad_res();
        t_tdm();
        t_bad_wid();
        t_divider();
        t_underrun();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule